// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration register space of one device function. A bus-side port carries one access per cycle. Each access packs a bus number, a device/function number and a register offset into a 24-bit address, and gives a length of 1, 2 or 4 bytes. The access reaches the register bytes only when both the bus number and the device/function number match the values the block is built with. Any other access is a miss. A read that misses returns all ones, sized to the access length. A write that misses changes nothing.

Each byte has a write mask that is fixed when the block is built. The mask follows the header rules: identity bytes are read-only, the command register has three writable bits, and the upper part of the space is fully writable. Each base-address register gets a mask derived from its region size, so the type bits and the size bits read back unchanged. A write merges new data into a byte only where that byte's mask has a one. A one-cycle pulse tells downstream address decoding that the base-address window or the decode enables have changed.

The control is a small state machine with three states. `ST_IDLE` means no access was taken on the last edge. `ST_RD_RESP` means a read was taken and its data is now presented. `ST_WR_DONE` means a write was taken and its change pulse is now presented. Every state has the same three transitions: *take_read* goes to `ST_RD_RESP`, *take_write* goes to `ST_WR_DONE`, and *no_access* goes to `ST_IDLE`.

Top module: `cfg_space`

## Requirements
- R1: An access hits only when address bits 23:16 equal `BUS_NUM` and bits 15:8 equal `DEVFN`. Bits 7:0 are the byte offset. Any other access is a miss.
- R2: A read miss returns 32'h000000FF for length code 0 (1 byte), 32'h0000FFFF for code 1 (2 bytes), and 32'hFFFFFFFF for codes 2 and 3 (4 bytes).
- R3: `req_ready` is always high. A read taken on one edge raises `rsp_valid` for exactly the next cycle. Hit data is little-endian: the byte at the offset is in bits 7:0, and bits above the access length read as zero.
- R4: A 4-byte hit read at an offset above 8'hFC is served as a 2-byte read. A 2-byte read (including a fallen-back one) at offset 8'hFF is served as a 1-byte read.
- R5: A hit write updates each byte as (old & ~mask) | (new & mask). Bytes are taken from the offset upward in little-endian order. A byte that would fall past offset 8'hFF is dropped.
- R6: A write that misses leaves every register byte unchanged.
- R7: The bytes at offsets 8'h00 to 8'h03 read {DEVICE_ID, VENDOR_ID} and are read-only. At offset 8'h04 only bits 2:0 are writable. Offsets 8'h0C, 8'h3C and 8'h40 to 8'hFF are fully writable.
- R8: Base-address register n (n < NUM_BARS) sits at offset 8'h10 + 4n and has the 32-bit mask ~(2^k - 1), where k is its size exponent. Its bit 0 resets to 1 for an I/O region and to 0 for a memory region. A register with k = 0 reads zero and ignores writes.
- R9: The expansion ROM register at offset 8'h30 has the mask ~(2^ROM_LOG2 - 1) | 1.
- R10: `map_change` pulses in the cycle after a hit write that changes any byte in offsets 8'h10 to 8'h27, or that changes bit 0 or bit 1 of offset 8'h04. It stays low after every other write, and at all other times.
- R11: After reset, all register bytes hold their default values, and `rsp_valid` and `map_change` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Access can be taken (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus number, device/function number, byte offset |
| req_len | input | 2 | Length code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| map_change | output | 1 | Base-address or decode-enable change pulse |

## Verification
Write merging is driven with all-ones data, which exposes the mask directly, and with mixed data such as 32'h12345678, which shows that the masked-off bits keep their old value. Reads at offsets 8'hFC to 8'hFF with every length code separate the fallback rule from plain truncation. Writes that straddle offset 8'hFF separate the drop-past-end rule from address wrap. Command writes are chosen to flip only the bus-master bit, and base-address writes rewrite the same value, so the change pulse can be told apart from a pulse that fires on any write to those offsets.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

    localparam int CFG_BYTES = 256;
    localparam int LANES     = 4;

    typedef enum logic [1:0] {
        LEN_B1  = 2'd0,
        LEN_B2  = 2'd1,
        LEN_B4  = 2'd2,
        LEN_B4X = 2'd3
    } acc_len_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RESP = 2'd1,
        ST_WR_DONE = 2'd2
    } cfg_state_e;

    // number of bytes an access length code asks for
    function automatic logic [2:0] len_bytes(input logic [1:0] code);
        case (code)
            2'd0:    len_bytes = 3'd1;
            2'd1:    len_bytes = 3'd2;
            default: len_bytes = 3'd4;
        endcase
    endfunction

    // all-ones pattern returned by a read that nobody decodes
    function automatic logic [31:0] miss_value(input logic [1:0] code);
        case (code)
            2'd0:    miss_value = 32'h0000_00FF;
            2'd1:    miss_value = 32'h0000_FFFF;
            default: miss_value = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_mask_gen.sv
module cfg_mask_gen #(
    parameter logic [15:0]          VENDOR_ID  = 16'hA55A,
    parameter logic [15:0]          DEVICE_ID  = 16'h3C01,
    parameter logic [15:0]          CLASS_CODE = 16'h0200,
    parameter int                   NUM_BARS   = 6,
    parameter logic [NUM_BARS*5-1:0] BAR_LOG2  = '0,
    parameter logic [NUM_BARS-1:0]  BAR_IO     = '0,
    parameter int                   ROM_LOG2   = 16
) (
    output logic [cfg_space_pkg::CFG_BYTES-1:0][7:0] wmask,
    output logic [cfg_space_pkg::CFG_BYTES-1:0][7:0] defval
);
    import cfg_space_pkg::*;

    localparam int BAR_BASE = 16;
    localparam int BAR_END  = BAR_BASE + 4 * NUM_BARS;
    localparam int ROM_BASE = 48;

    function automatic logic [7:0] mask_of(input int o);
        logic [31:0] m32;
        int          b;
        int          k;
        mask_of = 8'h00;
        if (o == 4) begin
            mask_of = 8'h07;
        end else if (o == 12 || o == 60 || o >= 64) begin
            mask_of = 8'hFF;
        end else if (o >= BAR_BASE && o < BAR_END) begin
            b = (o - BAR_BASE) / 4;
            k = int'(BAR_LOG2[b*5 +: 5]);
            if (k != 0) begin
                m32     = ~((32'd1 << k) - 32'd1);
                mask_of = m32[(o % 4) * 8 +: 8];
            end
        end else if (o >= ROM_BASE && o < ROM_BASE + 4 && ROM_LOG2 != 0) begin
            m32     = ~((32'd1 << ROM_LOG2) - 32'd1) | 32'd1;
            mask_of = m32[(o - ROM_BASE) * 8 +: 8];
        end
    endfunction

    function automatic logic [7:0] default_of(input int o);
        int b;
        default_of = 8'h00;
        case (o)
            0:  default_of = VENDOR_ID[7:0];
            1:  default_of = VENDOR_ID[15:8];
            2:  default_of = DEVICE_ID[7:0];
            3:  default_of = DEVICE_ID[15:8];
            10: default_of = CLASS_CODE[7:0];
            11: default_of = CLASS_CODE[15:8];
            default: begin
                if (o >= BAR_BASE && o < BAR_END && (o % 4) == 0) begin
                    b = (o - BAR_BASE) / 4;
                    if (BAR_LOG2[b*5 +: 5] != 5'd0)
                        default_of = {7'd0, BAR_IO[b]};
                end
            end
        endcase
    endfunction

    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_byte
        assign wmask[g]  = mask_of(g);
        assign defval[g] = default_of(g);
    end

endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store #(
    parameter int NBYTES = 256,
    parameter int NLANES = 4,
    localparam int AW    = $clog2(NBYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NBYTES-1:0][7:0]       defval,
    input  logic [NLANES-1:0]            lane_en,
    input  logic [NLANES-1:0][AW-1:0]    lane_addr,
    input  logic [NLANES-1:0][7:0]       lane_new,
    output logic [NBYTES-1:0][7:0]       bytes_q
);

    for (genvar j = 0; j < NBYTES; j++) begin : g_cell
        logic [7:0] nxt;

        always_comb begin
            nxt = bytes_q[j];
            for (int i = 0; i < NLANES; i++) begin
                if (lane_en[i] && lane_addr[i] == AW'(j))
                    nxt = lane_new[i];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) bytes_q[j] <= defval[j];
            else        bytes_q[j] <= nxt;
        end
    end

endmodule

// File: rtl/cfg_read_path.sv
module cfg_read_path (
    input  logic [cfg_space_pkg::CFG_BYTES-1:0][7:0] bytes_q,
    input  logic [7:0]                               offset,
    input  logic [1:0]                               len_code,
    input  logic                                     hit,
    output logic [31:0]                              rdata
);
    import cfg_space_pkg::*;

    logic [2:0] served;

    // length actually served after the end-of-space fallback
    always_comb begin
        unique case (acc_len_e'(len_code))
            LEN_B1:  served = 3'd1;
            LEN_B2:  served = (offset > 8'hFE) ? 3'd1 : 3'd2;
            default: served = (offset > 8'hFC) ?
                              ((offset > 8'hFE) ? 3'd1 : 3'd2) : 3'd4;
        endcase
    end

    always_comb begin
        rdata = '0;
        if (!hit) begin
            rdata = miss_value(len_code);
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (3'(i) < served)
                    rdata[i*8 +: 8] = bytes_q[offset + 8'(i)];
            end
        end
    end

endmodule

// File: rtl/cfg_space.sv
module cfg_space #(
    parameter logic [7:0]            BUS_NUM    = 8'h00,
    parameter logic [7:0]            DEVFN      = 8'h18,
    parameter logic [15:0]           VENDOR_ID  = 16'hA55A,
    parameter logic [15:0]           DEVICE_ID  = 16'h3C01,
    parameter logic [15:0]           CLASS_CODE = 16'h0200,
    parameter int                    NUM_BARS   = 6,
    parameter logic [NUM_BARS*5-1:0] BAR_LOG2   = {5'd0, 5'd0, 5'd0, 5'd20, 5'd12, 5'd4},
    parameter logic [NUM_BARS-1:0]   BAR_IO     = 6'b000001,
    parameter int                    ROM_LOG2   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [23:0] req_addr,
    input  logic [1:0]  req_len,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        map_change
);
    import cfg_space_pkg::*;

    localparam int          BAR_BASE = 16;
    localparam int          BAR_END  = BAR_BASE + 4 * NUM_BARS;
    localparam logic [7:0]  CMD_OFS  = 8'h04;
    localparam logic [7:0]  WIN_LO   = 8'h10;
    localparam logic [7:0]  WIN_HI   = 8'h27;

    logic [CFG_BYTES-1:0][7:0] wmask;
    logic [CFG_BYTES-1:0][7:0] defval;
    logic [CFG_BYTES-1:0][7:0] bytes_q;

    logic [7:0]  acc_bus;
    logic [7:0]  acc_devfn;
    logic [7:0]  acc_ofs;
    logic        hit;
    logic        take;
    logic        take_rd;
    logic        take_wr;
    logic [2:0]  nbytes;
    logic [31:0] rd_comb;

    logic [LANES-1:0]       lane_en;
    logic [LANES-1:0][7:0]  lane_addr;
    logic [LANES-1:0][7:0]  lane_new;
    logic [LANES-1:0]       lane_chg;

    cfg_state_e  state_q;
    cfg_state_e  state_d;
    logic [31:0] rdata_q;
    logic        chg_q;

    // ---- address split and decode ----
    assign acc_bus   = req_addr[23:16];
    assign acc_devfn = req_addr[15:8];
    assign acc_ofs   = req_addr[7:0];
    assign hit       = (acc_bus == BUS_NUM) && (acc_devfn == DEVFN);
    assign req_ready = 1'b1;
    assign take      = req_valid && req_ready;
    assign take_rd   = take && !req_write;
    assign take_wr   = take && req_write;
    assign nbytes    = len_bytes(req_len);

    cfg_mask_gen #(
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .CLASS_CODE (CLASS_CODE),
        .NUM_BARS   (NUM_BARS),
        .BAR_LOG2   (BAR_LOG2),
        .BAR_IO     (BAR_IO),
        .ROM_LOG2   (ROM_LOG2)
    ) u_masks (
        .wmask  (wmask),
        .defval (defval)
    );

    // ---- write lanes: merge under mask, drop bytes past the top ----
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [8:0] a9;
        logic [7:0] old_b;
        logic [7:0] m_b;
        logic [7:0] d_b;
        logic       in_win;
        logic       cmd_dec;

        assign a9           = {1'b0, acc_ofs} + 9'(i);
        assign lane_addr[i] = a9[7:0];
        assign old_b        = bytes_q[a9[7:0]];
        assign m_b          = wmask[a9[7:0]];
        assign d_b          = req_wdata[i*8 +: 8];
        assign lane_en[i]   = take_wr && hit && (3'(i) < nbytes) && !a9[8];
        assign lane_new[i]  = (old_b & ~m_b) | (d_b & m_b);
        assign in_win       = (a9[7:0] >= WIN_LO) && (a9[7:0] <= WIN_HI);
        assign cmd_dec      = (a9[7:0] == CMD_OFS) &&
                              ((old_b[1:0] ^ lane_new[i][1:0]) != 2'b00);
        assign lane_chg[i]  = lane_en[i] &&
                              ((in_win && (lane_new[i] != old_b)) || cmd_dec);
    end

    cfg_byte_store #(
        .NBYTES (CFG_BYTES),
        .NLANES (LANES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .defval    (defval),
        .lane_en   (lane_en),
        .lane_addr (lane_addr),
        .lane_new  (lane_new),
        .bytes_q   (bytes_q)
    );

    cfg_read_path u_read (
        .bytes_q  (bytes_q),
        .offset   (acc_ofs),
        .len_code (req_len),
        .hit      (hit),
        .rdata    (rd_comb)
    );

    // ---- state machine: next state ----
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_RD_RESP, ST_WR_DONE: begin
                if (take_rd)      state_d = ST_RD_RESP;   // take_read
                else if (take_wr) state_d = ST_WR_DONE;   // take_write
                else              state_d = ST_IDLE;      // no_access
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---- state register and response holding registers ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
            chg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_rd) rdata_q <= rd_comb;
            chg_q <= take_wr && (lane_chg != '0);
        end
    end

    // ---- outputs per state ----
    always_comb begin
        rsp_valid  = 1'b0;
        map_change = 1'b0;
        rsp_rdata  = rdata_q;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RD_RESP: rsp_valid  = 1'b1;
            ST_WR_DONE: map_change = chg_q;
            default:    ;
        endcase
    end

    if (BAR_END > 48) begin : g_bad_bars
        initial $error("cfg_space: NUM_BARS overlaps the ROM register");
    end

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
    parameter logic [7:0]  BUS_NUM   = 8'h00,
    parameter logic [7:0]  DEVFN     = 8'h18,
    parameter logic [15:0] VENDOR_ID = 16'hA55A,
    parameter logic [15:0] DEVICE_ID = 16'h3C01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [23:0] req_addr,
    input logic [1:0]  req_len,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        map_change
);
    import cfg_space_pkg::*;

    logic rd_take;
    logic wr_take;
    logic hit_in;

    assign rd_take = req_valid && req_ready && !req_write;
    assign wr_take = req_valid && req_ready && req_write;
    assign hit_in  = (req_addr[23:16] == BUS_NUM) && (req_addr[15:8] == DEVFN);

    // R3: every taken read answers in the next cycle
    p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> rsp_valid);

    // R3: a response only follows a taken read
    p_rsp_only_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_take));

    // R10: the change pulse only follows a taken write
    p_change_only_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        map_change |-> $past(wr_take));

    // R2: a read miss returns all ones sized to the length
    p_miss_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && !hit_in) |=> (rsp_rdata == miss_value($past(req_len))));

    // R7: identity dword never changes
    p_ident_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && hit_in && req_addr[7:0] == 8'h00 && req_len[1])
        |=> (rsp_rdata == {DEVICE_ID, VENDOR_ID}));

    // R4: any hit read at the last offset serves one byte only
    p_last_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && hit_in && req_addr[7:0] == 8'hFF) |=> (rsp_rdata[31:8] == 24'd0));

    // R11: response and pulse never both high
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && map_change));

endmodule

bind cfg_space cfg_space_chk #(
    .BUS_NUM   (BUS_NUM),
    .DEVFN     (DEVFN),
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .map_change (map_change)
);

// File: tb/cfg_space_test.sv
module cfg_space_test;

    localparam logic [7:0] MY_BUS = 8'h00;
    localparam logic [7:0] MY_DF  = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        map_change;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       etag_q[$];
    logic        chg_q[$];
    string       ctag_q[$];
    logic        rd_acc = 1'b0;
    logic        wr_acc = 1'b0;

    always #2.5 clk = ~clk;

    cfg_space uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .map_change (map_change)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] at(input logic [7:0] b, input logic [7:0] d, input logic [7:0] o);
        return {b, d, o};
    endfunction

    // driver: one access per call, pushing the expectation first
    task automatic rd(input string tag, input logic [23:0] a, input logic [1:0] l, input logic [31:0] exp);
        exp_q.push_back(exp);
        etag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_len = l; req_wdata = '0;
    endtask

    task automatic wr(input string tag, input logic [23:0] a, input logic [1:0] l,
                      input logic [31:0] d, input logic chg);
        chg_q.push_back(chg);
        ctag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_len = l; req_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
        end
    endtask

    // bench-side record of what was offered on each edge
    always @(posedge clk) begin
        rd_acc <= rst_n && req_valid && !req_write;
        wr_acc <= rst_n && req_valid && req_write;
    end

    // monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rd_acc) begin
                if (exp_q.size() == 0) begin
                    check("R3 response without expectation", 32'd1, 32'd0);
                end else begin
                    string t;
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    t = etag_q.pop_front();
                    check({t, " valid"}, {31'd0, rsp_valid}, 32'd1);
                    check(t, rsp_rdata, e);
                end
            end else if (rsp_valid) begin
                check("R3 stray rsp_valid", 32'd1, 32'd0);
            end
            if (wr_acc) begin
                if (chg_q.size() == 0) begin
                    check("R10 write without expectation", 32'd1, 32'd0);
                end else begin
                    string t;
                    logic e;
                    e = chg_q.pop_front();
                    t = ctag_q.pop_front();
                    check(t, {31'd0, map_change}, {31'd0, e});
                end
            end else if (map_change) begin
                check("R10 stray map_change", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R11 reset map_change", {31'd0, map_change}, 32'd0);
        check("R3 ready high", {31'd0, req_ready}, 32'd1);

        // R11 / R3 defaults and little-endian packing
        rd("R11 ident dword", at(MY_BUS, MY_DF, 8'h00), 2'd2, 32'h3C01_A55A);
        rd("R3 one byte", at(MY_BUS, MY_DF, 8'h00), 2'd0, 32'h0000_005A);
        rd("R3 two bytes", at(MY_BUS, MY_DF, 8'h01), 2'd1, 32'h0000_01A5);
        rd("R11 class code", at(MY_BUS, MY_DF, 8'h08), 2'd2, 32'h0200_0000);
        rd("R8 bar0 io type", at(MY_BUS, MY_DF, 8'h10), 2'd2, 32'h0000_0001);

        // R1 / R2 misses
        rd("R2 miss len0", at(8'h01, MY_DF, 8'h00), 2'd0, 32'h0000_00FF);
        rd("R2 miss len1", at(8'h01, MY_DF, 8'h00), 2'd1, 32'h0000_FFFF);
        rd("R2 miss len2", at(8'h01, MY_DF, 8'h00), 2'd2, 32'hFFFF_FFFF);
        rd("R2 miss len3", at(8'h01, MY_DF, 8'h00), 2'd3, 32'hFFFF_FFFF);
        rd("R1 miss devfn", at(MY_BUS, 8'h19, 8'h00), 2'd1, 32'h0000_FFFF);

        // R7 read-only identity, command mask
        wr("R7 ident write", at(MY_BUS, MY_DF, 8'h00), 2'd2, 32'hFFFF_FFFF, 1'b0);
        rd("R7 ident kept", at(MY_BUS, MY_DF, 8'h00), 2'd2, 32'h3C01_A55A);
        wr("R10 cmd enables on", at(MY_BUS, MY_DF, 8'h04), 2'd1, 32'h0000_FFFF, 1'b1);
        rd("R7 cmd mask", at(MY_BUS, MY_DF, 8'h04), 2'd1, 32'h0000_0007);
        wr("R10 cmd same value", at(MY_BUS, MY_DF, 8'h04), 2'd1, 32'h0000_0007, 1'b0);
        wr("R10 cmd enables off", at(MY_BUS, MY_DF, 8'h04), 2'd0, 32'h0000_0004, 1'b1);
        wr("R10 cmd master only", at(MY_BUS, MY_DF, 8'h04), 2'd0, 32'h0000_0000, 1'b0);
        rd("R7 cmd cleared", at(MY_BUS, MY_DF, 8'h04), 2'd0, 32'h0000_0000);

        // R8 base-address masks
        wr("R10 bar0 sizing", at(MY_BUS, MY_DF, 8'h10), 2'd2, 32'hFFFF_FFFF, 1'b1);
        rd("R8 bar0 mask", at(MY_BUS, MY_DF, 8'h10), 2'd2, 32'hFFFF_FFF1);
        wr("R10 bar0 same", at(MY_BUS, MY_DF, 8'h10), 2'd2, 32'hFFFF_FFFF, 1'b0);
        wr("R5 bar0 merge", at(MY_BUS, MY_DF, 8'h10), 2'd2, 32'h1234_5678, 1'b1);
        rd("R5 bar0 merged", at(MY_BUS, MY_DF, 8'h10), 2'd2, 32'h1234_5671);
        wr("R10 bar1 sizing", at(MY_BUS, MY_DF, 8'h14), 2'd2, 32'hFFFF_FFFF, 1'b1);
        rd("R8 bar1 mask", at(MY_BUS, MY_DF, 8'h14), 2'd2, 32'hFFFF_F000);
        wr("R8 bar3 absent write", at(MY_BUS, MY_DF, 8'h1C), 2'd2, 32'hFFFF_FFFF, 1'b0);
        rd("R8 bar3 absent", at(MY_BUS, MY_DF, 8'h1C), 2'd2, 32'h0000_0000);

        // R9 expansion ROM
        wr("R9 rom write no pulse", at(MY_BUS, MY_DF, 8'h30), 2'd2, 32'hFFFF_FFFF, 1'b0);
        rd("R9 rom mask", at(MY_BUS, MY_DF, 8'h30), 2'd2, 32'hFFFF_0001);

        // R7 fully writable bytes
        wr("R7 cache line", at(MY_BUS, MY_DF, 8'h0C), 2'd0, 32'h0000_00AB, 1'b0);
        wr("R7 int line", at(MY_BUS, MY_DF, 8'h3C), 2'd0, 32'h0000_005C, 1'b0);
        rd("R7 cache line rd", at(MY_BUS, MY_DF, 8'h0C), 2'd0, 32'h0000_00AB);
        rd("R7 int line rd", at(MY_BUS, MY_DF, 8'h3C), 2'd0, 32'h0000_005C);

        // R5 truncation at the top, R4 fallback
        wr("R5 straddle top", at(MY_BUS, MY_DF, 8'hFE), 2'd2, 32'h4433_2211, 1'b0);
        rd("R5 top dword", at(MY_BUS, MY_DF, 8'hFC), 2'd2, 32'h2211_0000);
        rd("R5 no wrap to 0", at(MY_BUS, MY_DF, 8'h00), 2'd1, 32'h0000_A55A);
        rd("R4 dword at FD", at(MY_BUS, MY_DF, 8'hFD), 2'd2, 32'h0000_1100);
        rd("R4 word at FF", at(MY_BUS, MY_DF, 8'hFF), 2'd1, 32'h0000_0022);
        rd("R4 dword at FF", at(MY_BUS, MY_DF, 8'hFF), 2'd3, 32'h0000_0022);

        // R6 write miss, then R5 hit write
        wr("R6 miss write", at(8'h02, MY_DF, 8'h40), 2'd2, 32'hDEAD_BEEF, 1'b0);
        rd("R6 miss untouched", at(MY_BUS, MY_DF, 8'h40), 2'd2, 32'h0000_0000);
        wr("R6 miss bar write", at(MY_BUS, 8'h20, 8'h10), 2'd2, 32'h0000_0000, 1'b0);
        rd("R6 bar untouched", at(MY_BUS, MY_DF, 8'h10), 2'd2, 32'h1234_5671);
        wr("R5 full write", at(MY_BUS, MY_DF, 8'h40), 2'd2, 32'h1234_5678, 1'b0);
        rd("R5 full read", at(MY_BUS, MY_DF, 8'h40), 2'd2, 32'h1234_5678);
        rd("R3 byte lane", at(MY_BUS, MY_DF, 8'h42), 2'd0, 32'h0000_0034);
        wr("R5 word write", at(MY_BUS, MY_DF, 8'h41), 2'd1, 32'hFFFF_AABB, 1'b0);
        rd("R5 word merged", at(MY_BUS, MY_DF, 8'h40), 2'd2, 32'h12AA_BB78);

        idle(4);
        check("R3 all responses seen", exp_q.size(), 32'd0);
        check("R10 all writes seen", chg_q.size(), 32'd0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule